// File: doc/BRIEF.md
# Address-Sequence Bank Unlock Detector

This block sits beside a memory that shares its bus with other devices. It holds that memory's bank selection closed until the host has proved its intent by walking a secret pattern across four address lines. The host signals each qualified read cycle with a strobe. On the first clock edge where that strobe is seen high, the block samples a four-bit slice of the address.

A sequence opens with a read whose watched slice is all ones. Sixteen reads then follow, and each one must carry the next four-bit group of a 64-bit key. The key is a parameter, and its least significant group comes first. After the last group matches, the slice presented on the next read becomes the bank index, and the bank-selected flag is raised.

Reset leaves every bank deselected, so several such devices can sit on one bus and none of them answers. Any wrong group discards the progress made so far. A new selection can be made at any time by repeating the whole sequence, and the current selection stays in force while that happens. The pins are plain control and status signals, with no stream handshake. The address slice is sampled only on the strobe's leading edge and cannot be stalled.

Top module: `bnk_unlock`

## Requirements
- R1: While reset (rst_n low) is sampled at a clock edge, the next state is bank_sel = 0 and bank_idx = 0.
- R2: addr_nib is sampled only at the clock edge where cyc_stb is first seen high. Values on addr_nib at any other edge have no effect on the outputs.
- R3: Sixteen correct key groups followed by an index read do not select a bank unless an all-ones (4'hF) read comes first.
- R4: Key step k (k = 0 for the first read after the 4'hF read, up to 15) must present KEY[4k+3:4k]. The least significant group is therefore compared first.
- R5: A read that does not match the expected key group abandons the sequence. If that read is 4'hF, it counts as a fresh opening read, and the next read is compared with step 0.
- R6: On the read that follows the sixteenth matching group, bank_idx takes that read's addr_nib and bank_sel becomes 1.
- R7: A selected bank stays selected with an unchanged index while a later sequence is entered. A complete later sequence replaces the index.
- R8: A strobe held high for several clocks counts as one read. The strobe must be seen low for at least one clock before the next read counts.
- R9: Both outputs change at the clock edge that first samples the strobe high on the index read, and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cyc_stb | input | 1 | High during a qualified read cycle; only its leading edge counts |
| addr_nib | input | 4 | The four watched address lines |
| bank_sel | output | 1 | A bank is selected |
| bank_idx | output | 4 | Index of the selected bank |

## Verification
A read counts at the first rising clock edge that sees cyc_stb high. There is no pipeline beyond the strobe's history flop, so the outputs change at that same edge and can be read half a period later. The bench drives each read on a falling edge and samples bank_sel and bank_idx on the falling edge that follows the counting rising edge. For R9 it also samples just before that rising edge, to confirm that nothing has changed early. Sweeps cover every bank index, a wrong group at each of the sixteen key steps, and held strobes during which the address moves.

// File: rtl/bnk_unlock_pkg.sv
package bnk_unlock_pkg;

  typedef enum logic [1:0] {
    ST_WAIT = 2'd0,   // waiting for the all-ones opening read
    ST_KEY  = 2'd1,   // comparing key groups
    ST_CAPT = 2'd2    // next read carries the bank index
  } seq_state_e;

endpackage

// File: rtl/bnk_stb_edge.sv
module bnk_stb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_i,
  output logic evt_o
);

  logic stb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) stb_q <= 1'b0;
    else        stb_q <= stb_i;
  end

  assign evt_o = stb_i && !stb_q;

  // R8: a read event is never followed directly by another
  a_r8_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);

endmodule

// File: rtl/bnk_key_seq.sv
module bnk_key_seq
  import bnk_unlock_pkg::*;
#(
  parameter int NIB_W     = 4,
  parameter int KEY_STEPS = 16,
  parameter logic [NIB_W*KEY_STEPS-1:0] KEY = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             cap_o
);

  localparam int CNT_W = (KEY_STEPS > 1) ? $clog2(KEY_STEPS) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(KEY_STEPS - 1);
  localparam logic [NIB_W-1:0] PREAMBLE  = {NIB_W{1'b1}};

  seq_state_e       state_q, state_d;
  logic [CNT_W-1:0] step_q, step_d;
  logic [NIB_W-1:0] exp_nib;
  logic             hit;

  assign exp_nib = KEY[step_q*NIB_W +: NIB_W];
  assign hit     = (nib_i == exp_nib);

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    if (evt_i) begin
      unique case (state_q)
        ST_WAIT: begin
          if (nib_i == PREAMBLE) begin
            state_d = ST_KEY;
            step_d  = '0;
          end
        end
        ST_KEY: begin
          if (hit) begin
            if (step_q == LAST_STEP) state_d = ST_CAPT;
            else                     step_d  = step_q + 1'b1;
          end else if (nib_i == PREAMBLE) begin
            state_d = ST_KEY;
            step_d  = '0;
          end else begin
            state_d = ST_WAIT;
            step_d  = '0;
          end
        end
        ST_CAPT: begin
          state_d = ST_WAIT;
          step_d  = '0;
        end
        default: begin
          state_d = ST_WAIT;
          step_d  = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_WAIT;
      step_q  <= '0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
    end
  end

  assign cap_o = evt_i && (state_q == ST_CAPT);

  // R8: no progress without a read event
  a_r8_no_step_without_event: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_i |=> ($stable(step_q) && $stable(state_q)));

  // R4: a matching group advances the step by exactly one
  a_r4_step_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && state_q == ST_KEY && hit && step_q != LAST_STEP)
      |=> (state_q == ST_KEY && step_q == CNT_W'($past(step_q) + 1'b1)));

  // R5: a wrong group that is not all ones returns to waiting
  a_r5_mismatch_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && state_q == ST_KEY && !hit && nib_i != PREAMBLE)
      |=> (state_q == ST_WAIT));

  // R5: a wrong all-ones group restarts at step zero
  a_r5_preamble_rearm: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_i && state_q == ST_KEY && !hit && nib_i == PREAMBLE)
      |=> (state_q == ST_KEY && step_q == '0));

endmodule

// File: rtl/bnk_sel_reg.sv
module bnk_sel_reg #(
  parameter int NIB_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             sel_o,
  output logic [NIB_W-1:0] idx_o
);

  logic             sel_q;
  logic [NIB_W-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      idx_q <= '0;
    end else if (cap_i) begin
      sel_q <= 1'b1;
      idx_q <= nib_i;
    end
  end

  assign sel_o = sel_q;
  assign idx_o = idx_q;

  // R1: reset clears the selection
  a_r1_reset_clear: assert property (@(posedge clk)
    !rst_n |=> (!sel_q && idx_q == '0));

endmodule

// File: rtl/bnk_unlock.sv
module bnk_unlock #(
  parameter int NIB_W     = 4,
  parameter int KEY_STEPS = 16,
  parameter logic [NIB_W*KEY_STEPS-1:0] KEY = 64'h3C5A_0E96_D217_84B6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_stb,
  input  logic [NIB_W-1:0] addr_nib,
  output logic             bank_sel,
  output logic [NIB_W-1:0] bank_idx
);

  logic evt;
  logic cap;

  bnk_stb_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .stb_i (cyc_stb),
    .evt_o (evt)
  );

  bnk_key_seq #(
    .NIB_W     (NIB_W),
    .KEY_STEPS (KEY_STEPS),
    .KEY       (KEY)
  ) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .evt_i (evt),
    .nib_i (addr_nib),
    .cap_o (cap)
  );

  bnk_sel_reg #(
    .NIB_W (NIB_W)
  ) u_sel (
    .clk   (clk),
    .rst_n (rst_n),
    .cap_i (cap),
    .nib_i (addr_nib),
    .sel_o (bank_sel),
    .idx_o (bank_idx)
  );

  // R7: outputs hold unless a capture happens
  a_r7_hold_without_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> ($stable(bank_idx) && $stable(bank_sel)));

  // R6: a capture selects and takes the sampled index
  a_r6_capture_loads: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (bank_sel && bank_idx == $past(addr_nib)));

endmodule

// File: tb/tb_bnk_unlock.sv
module tb_bnk_unlock;

  localparam int CLK_PERIOD = 10;
  localparam logic [63:0] KEY = 64'h3C5A_0E96_D217_84B6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_stb = 1'b0;
  logic [3:0] addr_nib = 4'h0;
  logic       bank_sel;
  logic [3:0] bank_idx;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bnk_unlock #(.NIB_W(4), .KEY_STEPS(16), .KEY(KEY)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_stb  (cyc_stb),
    .addr_nib (addr_nib),
    .bank_sel (bank_sel),
    .bank_idx (bank_idx)
  );

  function automatic logic [3:0] knib(int k);
    return KEY[k*4 +: 4];
  endfunction

  task automatic chk(input logic es, input logic [3:0] ei, input string tag);
    n_vec++;
    if (bank_sel !== es || bank_idx !== ei) begin
      n_bad++;
      $display("FAIL %s: sel=%0b idx=%h expected sel=%0b idx=%h", tag, bank_sel, bank_idx, es, ei);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cyc_stb = 1'b0; addr_nib = 4'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one read: strobe high for 'hold' clocks, address scrambled while low
  task automatic rd(input logic [3:0] nib, input int hold);
    @(negedge clk);
    addr_nib = nib; cyc_stb = 1'b1;
    repeat (hold) @(negedge clk);
    cyc_stb = 1'b0; addr_nib = ~nib;
  endtask

  task automatic full_key();
    rd(4'hF, 1);
    for (int k = 0; k < 16; k++) rd(knib(k), 1);
  endtask

  initial begin
    do_reset();
    // R1
    chk(1'b0, 4'h0, "R1 after reset");

    // R3: key without opening read
    for (int k = 0; k < 16; k++) rd(knib(k), 1);
    rd(4'h7, 1);
    chk(1'b0, 4'h0, "R3 no preamble");

    // R6/R4/R7: sweep all indices
    for (int b = 0; b < 16; b++) begin
      full_key();
      if (b > 0) chk(1'b1, 4'(b - 1), "R7 held during reentry");
      else       chk(1'b0, 4'h0, "R6 not yet selected");
      rd(4'(b), 1);
      chk(1'b1, 4'(b), "R6 index captured");
    end

    // R5: wrong group at each step
    for (int s = 0; s < 16; s++) begin
      logic [3:0] w;
      do_reset();
      w = knib(s) ^ 4'h1;
      if (w == 4'hF) w = knib(s) ^ 4'h2;
      rd(4'hF, 1);
      for (int k = 0; k < s; k++) rd(knib(k), 1);
      rd(w, 1);
      for (int k = s + 1; k < 16; k++) rd(knib(k), 1);
      rd(4'h9, 1);
      chk(1'b0, 4'h0, "R5 mismatch restarts");
    end

    // R5: all-ones mismatch re-arms
    do_reset();
    rd(4'hF, 1);
    for (int k = 0; k < 3; k++) rd(knib(k), 1);
    rd(4'hF, 1);
    for (int k = 0; k < 16; k++) rd(knib(k), 1);
    rd(4'hA, 1);
    chk(1'b1, 4'hA, "R5 F mismatch is new preamble");

    // R8/R2: held strobes with address moving while held
    do_reset();
    rd(4'hF, 3);
    for (int k = 0; k < 16; k++) begin
      @(negedge clk);
      addr_nib = knib(k); cyc_stb = 1'b1;
      @(negedge clk); addr_nib = 4'hF;
      @(negedge clk); addr_nib = ~knib(k);
      @(negedge clk); cyc_stb = 1'b0; addr_nib = 4'hF;
    end
    rd(4'h5, 2);
    chk(1'b1, 4'h5, "R8 held strobe counts once");

    // R8: strobe never dropped counts one read only
    do_reset();
    @(negedge clk);
    cyc_stb = 1'b1; addr_nib = 4'hF;
    for (int k = 0; k < 16; k++) begin
      @(negedge clk); addr_nib = knib(k);
    end
    @(negedge clk); addr_nib = 4'h3;
    @(negedge clk); cyc_stb = 1'b0;
    chk(1'b0, 4'h0, "R8 continuous strobe single read");

    // R9: timing of the index read
    do_reset();
    full_key();
    @(negedge clk);
    addr_nib = 4'hC; cyc_stb = 1'b1;
    #(CLK_PERIOD/2 - 1);
    chk(1'b0, 4'h0, "R9 no early change");
    @(negedge clk);
    chk(1'b1, 4'hC, "R9 change at sampling edge");
    cyc_stb = 1'b0;
    // R2: further address motion without strobe
    for (int v = 0; v < 16; v++) begin
      @(negedge clk); addr_nib = 4'(v);
    end
    @(negedge clk);
    chk(1'b1, 4'hC, "R2 idle address ignored");

    // R1: reset after selection
    do_reset();
    chk(1'b0, 4'h0, "R1 reset deselects");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule